// File: doc/BRIEF.md
# Memory Window Base Registers with Size Discovery

This block holds the six memory-window base registers of a device configuration header. Host software reads and writes them through a small DWORD-indexed port with byte enables. Each slot is fixed at elaboration time. It can be unused, a 32-bit window, or the low half of a 64-bit window that takes the next slot as its upper half. Each window also has a power-of-two size and a prefetchable flag.

To learn a window's size, software writes all ones to the register and reads it back. Address bits below the window size are not storable, so they return zero. The lowest set bit that reads back shows the size and the alignment. Once the bases are placed and memory decoding is enabled, the block compares each incoming address with every active window. It reports the lowest-numbered window that matches and the byte offset inside that window. The decode path is combinational, from the address and the stored bases to the hit outputs.

Top module: `bar_sizing_regs`

## Requirements
- R1: Register indices 0 to 5 select the six slots. Indices 6 and 7 read as zero and writes to them are dropped. A register's read value changes only after a write to that index.
- R2: A slot that is not enabled, and is not the upper half of a 64-bit window, reads as zero and ignores writes. Its index never appears on the hit outputs.
- R3: Bits [3:0] of a window's low register are read-only. Bit 0 reads 0 (memory space). Bits [2:1] read 00 for a 32-bit window and 10 for a 64-bit window. Bit 3 reads the prefetchable flag.
- R4: In a low register, bits below log2 of the window size always read zero. After all ones is written, the register reads back the complement of (size - 1), with the type bits in bits [3:0].
- R5: The slot after a 64-bit window's low register is that window's upper 32 address bits. All of its bits are writable when the window is 4 GiB or smaller.
- R6: Only the bytes whose byte-enable bit is set are updated; `cfg_be_i[n]` covers data bits [8n+7:8n].
- R7: After reset, every stored address bit is zero, so each register shows only its type bits.
- R8: `hit_o` is high only while `mem_en_i` is high.
- R9: An address in the range [base, base + size) of an active window hits that window. `hit_bar_o` gives its low-register index and `hit_off_o` gives the address minus the base. A 32-bit window also requires `addr_i[63:32]` to be zero. A 64-bit window compares all 64 bits.
- R10: When windows overlap, the lowest-numbered matching window is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 3 | Register index |
| cfg_be_i | input | 4 | Byte enables for a write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_idx_i`, combinational |
| mem_en_i | input | 1 | Memory decode enable |
| addr_i | input | 64 | Address to decode |
| hit_o | output | 1 | Address falls in an active window |
| hit_bar_o | output | 3 | Index of the matching window's low register |
| hit_off_o | output | 64 | Byte offset within the matching window |

## Verification
A stored bit that escapes its writable mask shows up on the very next read of that index. It appears as a nonzero bit below the size boundary or as a corrupted type nibble. The same fault shows up at once as a decode miss for an address inside the window. A wrong upper-half pairing shows on the first decode of an address above 4 GiB: the window misses there, or hits with its high half ignored. A priority fault is only visible while two windows overlap, so the bench builds an overlap on purpose and then moves one window away.

// File: rtl/bar_cfg_pkg.sv
`timescale 1ns/1ps
package bar_cfg_pkg;
  localparam int unsigned NUM_BARS = 6;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned AW       = 64;
  localparam int unsigned SZ_W     = 6;

  typedef enum logic [1:0] {SLOT_OFF, SLOT_LO32, SLOT_LO64, SLOT_HI64} slot_role_e;

  // address bits at or above the window size
  function automatic logic [AW-1:0] win_mask(input int unsigned sz);
    return ~((64'd1 << sz) - 64'd1);
  endfunction

  function automatic slot_role_e slot_role(input logic [NUM_BARS-1:0] en,
                                           input logic [NUM_BARS-1:0] is64,
                                           input int unsigned i);
    if (i > 0) begin
      if (en[i-1] && is64[i-1] && (i - 1) < NUM_BARS - 1) return SLOT_HI64;
    end
    if (!en[i]) return SLOT_OFF;
    if (is64[i] && i < NUM_BARS - 1) return SLOT_LO64;
    return SLOT_LO32;
  endfunction
endpackage

// File: rtl/bar_reg_slot.sv
`timescale 1ns/1ps
module bar_reg_slot #(
  parameter logic [31:0] WMASK   = 32'h0,
  parameter logic [31:0] RO_BITS = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] base_o,
  output logic [31:0] rdata_o
);
  logic [31:0] base_q;
  logic [31:0] be_mask;

  always_comb begin
    for (int b = 0; b < 4; b++) be_mask[b*8 +: 8] = {8{be_i[b]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (wr_i) base_q <= ((base_q & ~be_mask) | (wdata_i & be_mask)) & WMASK;
  end

  assign base_o  = base_q;
  assign rdata_o = base_q | RO_BITS;
endmodule

// File: rtl/bar_win_match.sv
`timescale 1ns/1ps
module bar_win_match #(
  parameter int unsigned NUM = 6,
  parameter int unsigned AW  = 64,
  parameter int unsigned IW  = 3
) (
  input  logic [NUM-1:0] valid_i,
  input  logic [AW-1:0]  base_i [NUM],
  input  logic [AW-1:0]  mask_i [NUM],
  input  logic [AW-1:0]  addr_i,
  input  logic           en_i,
  output logic           hit_o,
  output logic [IW-1:0]  idx_o,
  output logic [AW-1:0]  off_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    off_o = '0;
    // descending scan: lowest matching index is written last
    for (int k = NUM - 1; k >= 0; k--) begin
      if (en_i && valid_i[k] && ((addr_i & mask_i[k]) == base_i[k])) begin
        hit_o = 1'b1;
        idx_o = IW'(k);
        off_o = addr_i & ~mask_i[k];
      end
    end
  end
endmodule

// File: rtl/bar_sizing_regs.sv
`timescale 1ns/1ps
module bar_sizing_regs
  import bar_cfg_pkg::*;
#(
  parameter logic [NUM_BARS-1:0]      BAR_EN   = 6'b010101,
  parameter logic [NUM_BARS-1:0]      BAR_IS64 = 6'b000100,
  parameter logic [NUM_BARS-1:0]      BAR_PREF = 6'b000100,
  parameter logic [NUM_BARS*SZ_W-1:0] BAR_SZ   = {6'd0, 6'd7, 6'd0, 6'd20, 6'd0, 6'd12}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [3:0]       cfg_be_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic             mem_en_i,
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_bar_o,
  output logic [AW-1:0]    hit_off_o
);
  logic [31:0]       slot_base [NUM_BARS];
  logic [31:0]       slot_rd   [NUM_BARS];
  logic [NUM_BARS-1:0] win_valid;
  logic [AW-1:0]     win_base  [NUM_BARS];
  logic [AW-1:0]     win_msk   [NUM_BARS];

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
    localparam int unsigned SZ   = BAR_SZ[i*SZ_W +: SZ_W];
    localparam int unsigned PREV = (i > 0) ? i - 1 : 0;
    localparam int unsigned NXT  = (i < NUM_BARS - 1) ? i + 1 : i;
    localparam int unsigned PSZ  = BAR_SZ[PREV*SZ_W +: SZ_W];
    localparam slot_role_e  ROLE = slot_role(BAR_EN, BAR_IS64, i);
    localparam logic [AW-1:0] M  = win_mask(SZ);
    localparam logic [AW-1:0] PM = win_mask(PSZ);
    localparam logic [31:0] WMASK =
      (ROLE == SLOT_LO32 || ROLE == SLOT_LO64) ? M[31:0] :
      (ROLE == SLOT_HI64)                      ? PM[63:32] : 32'h0;
    localparam logic [31:0] RO_BITS =
      (ROLE == SLOT_LO32) ? {28'h0, BAR_PREF[i], 2'b00, 1'b0} :
      (ROLE == SLOT_LO64) ? {28'h0, BAR_PREF[i], 2'b10, 1'b0} : 32'h0;

    bar_reg_slot #(.WMASK(WMASK), .RO_BITS(RO_BITS)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_we_i && (cfg_idx_i == IDX_W'(i))),
      .be_i    (cfg_be_i),
      .wdata_i (cfg_wdata_i),
      .base_o  (slot_base[i]),
      .rdata_o (slot_rd[i])
    );

    assign win_valid[i] = (ROLE == SLOT_LO32) || (ROLE == SLOT_LO64);
    assign win_msk[i]   = M;
    if (ROLE == SLOT_LO64) begin : g_w64
      assign win_base[i] = {slot_base[NXT], slot_base[i]};
    end else begin : g_w32
      assign win_base[i] = {32'h0, slot_base[i]};
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int k = 0; k < NUM_BARS; k++) begin
      if (cfg_idx_i == IDX_W'(k)) cfg_rdata_o = slot_rd[k];
    end
  end

  bar_win_match #(.NUM(NUM_BARS), .AW(AW), .IW(IDX_W)) u_match (
    .valid_i (win_valid),
    .base_i  (win_base),
    .mask_i  (win_msk),
    .addr_i  (addr_i),
    .en_i    (mem_en_i),
    .hit_o   (hit_o),
    .idx_o   (hit_bar_o),
    .off_o   (hit_off_o)
  );
endmodule

// File: rtl/bar_regs_chk.sv
`timescale 1ns/1ps
module bar_regs_chk
  import bar_cfg_pkg::*;
#(
  parameter logic [NUM_BARS-1:0]      BAR_EN   = 6'b010101,
  parameter logic [NUM_BARS-1:0]      BAR_IS64 = 6'b000100,
  parameter logic [NUM_BARS-1:0]      BAR_PREF = 6'b000100,
  parameter logic [NUM_BARS*SZ_W-1:0] BAR_SZ   = {6'd0, 6'd7, 6'd0, 6'd20, 6'd0, 6'd12}
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [IDX_W-1:0] cfg_idx_i,
  input logic [3:0]       cfg_be_i,
  input logic [31:0]      cfg_wdata_i,
  input logic [31:0]      cfg_rdata_o,
  input logic             mem_en_i,
  input logic [AW-1:0]    addr_i,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_bar_o,
  input logic [AW-1:0]    hit_off_o
);
  localparam logic [7:0] EN_X   = {2'b00, BAR_EN};
  localparam logic [7:0] IS64_X = {2'b00, BAR_IS64};
  localparam logic [7:0] PREF_X = {2'b00, BAR_PREF};

  function automatic logic [AW-1:0] mask_of(input logic [IDX_W-1:0] idx);
    logic [AW-1:0] m;
    m = '1;
    for (int k = 0; k < NUM_BARS; k++)
      if (idx == IDX_W'(k)) m = win_mask(BAR_SZ[k*SZ_W +: SZ_W]);
    return m;
  endfunction

  logic [1:0] exp_type;
  assign exp_type = IS64_X[cfg_idx_i] ? 2'b10 : 2'b00;

  assert_hit_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> mem_en_i);

  assert_off_in_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((hit_off_o & mask_of(hit_bar_o)) == '0));

  assert_hit_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> EN_X[hit_bar_o]);

  assert_type_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_idx_i < 3'd6 && EN_X[cfg_idx_i]) |->
      (cfg_rdata_o[0] == 1'b0 && cfg_rdata_o[2:1] == exp_type &&
       cfg_rdata_o[3] == PREF_X[cfg_idx_i]));

  assert_high_idx_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_idx_i > 3'd5) |-> (cfg_rdata_o == 32'h0));

  assert_hold_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ((cfg_idx_i != $past(cfg_idx_i)) || $stable(cfg_rdata_o)));
endmodule

bind bar_sizing_regs bar_regs_chk #(
  .BAR_EN(BAR_EN), .BAR_IS64(BAR_IS64), .BAR_PREF(BAR_PREF), .BAR_SZ(BAR_SZ)
) u_chk (.*);

// File: tb/bar_sizing_regs_tb.sv
`timescale 1ns/1ps
module bar_sizing_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 1'b0;
  logic [63:0] addr = '0;
  logic        hit;
  logic [2:0]  hit_bar;
  logic [63:0] hit_off;

  always #2 clk = ~clk;

  bar_sizing_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .mem_en_i(mem_en), .addr_i(addr), .hit_o(hit), .hit_bar_o(hit_bar),
    .hit_off_o(hit_off)
  );

  typedef struct {
    bit          is_dec;
    logic [31:0] rd;
    bit          hit;
    logic [2:0]  bar;
    logic [63:0] off;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_be = be; cfg_wdata = d;
  endtask

  task automatic rd(input int idx, input logic [31:0] e, input string r);
    exp_t x;
    @(negedge clk);
    cfg_we = 1'b0; cfg_idx = idx[2:0];
    x.is_dec = 1'b0; x.rd = e; x.hit = 1'b0; x.bar = '0; x.off = '0; x.req = r;
    sbq.push_back(x);
  endtask

  task automatic dec(input logic en, input logic [63:0] a, input bit h,
                     input int b, input logic [63:0] o, input string r);
    exp_t x;
    @(negedge clk);
    cfg_we = 1'b0; mem_en = en; addr = a;
    x.is_dec = 1'b1; x.rd = '0; x.hit = h; x.bar = b[2:0]; x.off = o; x.req = r;
    sbq.push_back(x);
  endtask

  // monitor: compares one expected item per cycle, 1 ns after the driver
  always @(negedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t x;
      x = sbq.pop_front();
      checks++;
      if (!x.is_dec) begin
        if (cfg_rdata !== x.rd) begin
          fails++;
          $display("FAIL %s idx=%0d: actual %h expected %h", x.req, cfg_idx, cfg_rdata, x.rd);
        end
      end else if (hit !== x.hit || (x.hit && (hit_bar !== x.bar || hit_off !== x.off))) begin
        fails++;
        $display("FAIL %s addr=%h: actual hit=%b bar=%0d off=%h expected hit=%b bar=%0d off=%h",
                 x.req, addr, hit, hit_bar, hit_off, x.hit, x.bar, x.off);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 / R3 / R2 / R1: reset view
    rd(0, 32'h0000_0000, "R7 bar0 reset");
    rd(1, 32'h0000_0000, "R2 disabled slot reset");
    rd(2, 32'h0000_000C, "R3 64-bit prefetchable type bits");
    rd(3, 32'h0000_0000, "R7 upper half reset");
    rd(4, 32'h0000_0000, "R3 32-bit type bits");
    rd(6, 32'h0000_0000, "R1 index 6 reads zero");

    // R4 / R5 / R2 / R1: size probe
    for (int i = 0; i < 8; i++) wr(i, 32'hFFFF_FFFF, 4'hF);
    rd(0, 32'hFFFF_F000, "R4 4KiB probe");
    rd(1, 32'h0000_0000, "R2 disabled ignores write");
    rd(2, 32'hFFF0_000C, "R4 1MiB probe with type");
    rd(3, 32'hFFFF_FFFF, "R5 upper half fully writable");
    rd(4, 32'hFFFF_FF80, "R4 128B probe");
    rd(5, 32'h0000_0000, "R2 slot5 ignores write");
    rd(6, 32'h0000_0000, "R1 index 6 write dropped");
    rd(7, 32'h0000_0000, "R1 index 7 write dropped");

    // R6: byte enables
    wr(0, 32'h0000_0000, 4'b0100);
    rd(0, 32'hFF00_F000, "R6 only byte 2 cleared");
    wr(0, 32'h1234_5678, 4'hF);
    rd(0, 32'h1234_5000, "R6 full write masked by size");
    wr(3, 32'h0000_00AA, 4'b0001);
    rd(3, 32'hFFFF_FFAA, "R6 upper half byte 0 only");

    // place windows; bar4 inside bar0
    wr(0, 32'h8000_0000, 4'hF);
    wr(2, 32'h0030_0000, 4'hF);
    wr(3, 32'h0000_0001, 4'hF);
    wr(4, 32'h8000_0400, 4'hF);
    rd(4, 32'h8000_0400, "R4 bar4 placed");

    dec(1'b0, 64'h0000_0000_8000_0010, 1'b0, 0, 64'h0, "R8 decode disabled");
    dec(1'b1, 64'h0000_0000_8000_0010, 1'b1, 0, 64'h10, "R9 bar0 low edge");
    dec(1'b1, 64'h0000_0000_8000_0FFF, 1'b1, 0, 64'hFFF, "R9 bar0 top byte");
    dec(1'b1, 64'h0000_0000_8000_1000, 1'b0, 0, 64'h0, "R9 just past bar0");
    dec(1'b1, 64'h0000_0001_8000_0010, 1'b0, 0, 64'h0, "R9 32-bit window needs upper zero");
    dec(1'b1, 64'h0000_0001_0030_0000, 1'b1, 2, 64'h0, "R9 64-bit window base");
    dec(1'b1, 64'h0000_0001_003F_FFFF, 1'b1, 2, 64'hF_FFFF, "R9 64-bit window top");
    dec(1'b1, 64'h0000_0000_0030_0000, 1'b0, 0, 64'h0, "R5 upper half compared");
    dec(1'b1, 64'h0000_0001_0040_0000, 1'b0, 0, 64'h0, "R9 past 64-bit window");
    dec(1'b1, 64'h0000_0000_8000_0410, 1'b1, 0, 64'h410, "R10 overlap lowest wins");
    dec(1'b0, 64'h0000_0001_0030_0008, 1'b0, 0, 64'h0, "R8 disabled 64-bit");

    wr(0, 32'h9000_0000, 4'hF);
    dec(1'b1, 64'h0000_0000_8000_0410, 1'b1, 4, 64'h10, "R10 bar4 after bar0 moves");
    dec(1'b1, 64'h0000_0000_8000_047F, 1'b1, 4, 64'h7F, "R9 bar4 top byte");
    dec(1'b1, 64'h0000_0000_8000_0480, 1'b0, 0, 64'h0, "R9 past bar4");
    dec(1'b1, 64'h0000_0000_9000_0004, 1'b1, 0, 64'h4, "R9 bar0 new base");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule